// File: doc/BRIEF.md
# Dual-Issue Slot-Pairing Issue Unit

This block is the issue stage of a statically scheduled, two-wide, in-order core. Each cycle instruction memory can hand it one 64-bit fetch bundle that holds two 32-bit instruction words. The word at the 8-byte-aligned address is slot 0 and may only carry an ALU operation or a control-transfer operation. The word four bytes higher is slot 1 and may only carry a load or a store. The unit classifies both words and checks that the pairing obeys these fixed roles. It then routes slot 0 to the ALU/branch pipe and slot 1 to the load/store pipe in the same cycle, which gives an ideal rate of two instructions per cycle (CPI 0.5).

The compiler is trusted to schedule independent pairs and to pad empty slots with the all-zero NOP word, so the unit does no dependence checking. It does report faults. A bundle fetched from a misaligned address, a word with an undefined opcode, or a word placed in the wrong slot each suppresses both pipes and holds the fetch address. A separate fault code names each case. The unit also produces the next fetch address. Unconditional jumps in slot 0 redirect it. Conditional branches are statically predicted not taken.

Top module: `pair_issue_unit`

## Requirements
- R1: While reset is asserted and after it is released with no fetch, both pipe valids are 0, both instruction outputs are 0, the fault code is 0 and the next fetch address equals the RESET_PC parameter (default 0).
- R2: The slot 0 word is fetch_bundle_i[31:0] and the slot 1 word is fetch_bundle_i[63:32]. All outputs for a fetch register on the clock edge that samples fetch_vld_i high and appear one cycle later.
- R3: Words are classified by opcode bits [31:26]. The all-zero word is NOP. Opcode 0x00 (nonzero word) and opcodes 0x08-0x0F are ALU. Opcode 0x02 is a jump. Opcodes 0x04-0x05 are conditional branches. Opcodes 0x20-0x2F are loads and stores. Every other opcode is undefined.
- R4: A legal bundle issues an ALU, branch or jump word on the ALU pipe and a load/store word on the memory pipe in the same cycle. The instruction outputs carry the words unchanged, and an instruction output is 0 whenever its valid is 0.
- R5: The NOP word is legal in either slot. It raises no fault and issues nothing on its pipe.
- R6: A load/store word in slot 0, or an ALU, branch or jump word in slot 1, raises fault code 3. Both pipes are suppressed and the next fetch address equals the faulting fetch address.
- R7: An undefined opcode in either slot raises fault code 2, which takes precedence over code 3. Both pipes are suppressed and the fetch address is held.
- R8: A fetch address with any of bits [2:0] set raises fault code 1, which takes precedence over every other fault. Both pipes are suppressed and the fetch address is held.
- R9: A fault-free bundle whose slot 0 is not a jump sets the next fetch address to the fetch address plus 8. Conditional branches are predicted not taken.
- R10: A fault-free bundle whose slot 0 is a jump sets the next fetch address to {fetch_pc[31:28], word[25:0], 2'b00} with bits [2:0] forced to 0. The jump issues on the ALU pipe and a paired load/store still issues.
- R11: With fetch_vld_i low, both valids and the fault code are 0 and the next fetch address keeps its value, whatever the other inputs carry.
- R12: Register dependences between the two slots are not examined. A load that reads the register the paired ALU word writes still issues alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_vld_i | input | 1 | A bundle is presented this cycle |
| fetch_pc_i | input | 32 | Byte address of the bundle |
| fetch_bundle_i | input | 64 | Two instruction words, slot 0 in the low half |
| alu_vld_o | output | 1 | ALU/branch pipe receives an instruction |
| alu_ins_o | output | 32 | Instruction for the ALU/branch pipe |
| mem_vld_o | output | 1 | Load/store pipe receives an instruction |
| mem_ins_o | output | 32 | Instruction for the load/store pipe |
| fault_o | output | 2 | 0 none, 1 misaligned, 2 undefined opcode, 3 illegal pairing |
| next_pc_o | output | 32 | Address of the next bundle to fetch |

## Verification
The bench drives each slot-role violation in both directions: memory work in slot 0 and ALU, branch or jump work in slot 1. A unit that trusted the slot positions would issue a load down the ALU pipe, or two ALU operations at once. Misaligned addresses are combined with bundles that are undefined or mispaired, which exposes a wrong fault priority as the wrong code. A jump whose immediate has its low bit set shows whether the next address comes back 8-byte aligned. Several cases check that a faulting fetch holds the address rather than advancing by 8. NOP padding in each slot and an idle cycle carrying garbage show whether a filler word or an unqualified bundle leaks a valid or moves the fetch address.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;

   // Instruction class produced by the word classifier
   typedef enum logic [2:0] {
      CLS_NOP    = 3'd0,
      CLS_ALU    = 3'd1,
      CLS_BRANCH = 3'd2,
      CLS_JUMP   = 3'd3,
      CLS_MEM    = 3'd4,
      CLS_BAD    = 3'd5
   } ins_class_e;

   // Fault code; numeric values are visible on the fault port
   typedef enum logic [1:0] {
      FLT_NONE     = 2'd0,
      FLT_MISALIGN = 2'd1,
      FLT_UNKNOWN  = 2'd2,
      FLT_PAIRING  = 2'd3
   } fault_e;

   // Class is allowed in the ALU/branch slot
   function automatic logic fits_slot0(input ins_class_e c);
      return (c == CLS_NOP) || (c == CLS_ALU) || (c == CLS_BRANCH) || (c == CLS_JUMP);
   endfunction

   // Class is allowed in the load/store slot
   function automatic logic fits_slot1(input ins_class_e c);
      return (c == CLS_NOP) || (c == CLS_MEM);
   endfunction

endpackage

// File: rtl/pi_word_classify.sv
module pi_word_classify
   import pair_issue_pkg::*;
#(
   parameter int INS_W = 32,
   parameter int OPC_W = 6
) (
   input  logic [INS_W-1:0] word_i,
   output ins_class_e       cls_o
);

   localparam int IMM_W = INS_W - OPC_W;

   logic [OPC_W-1:0] opc;
   logic             is_zero;

   assign opc     = word_i[INS_W-1 -: OPC_W];
   assign is_zero = (word_i == '0);

   always_comb begin
      cls_o = CLS_BAD;
      if (is_zero) begin
         cls_o = CLS_NOP;
      end else begin
         unique casez (opc)
            6'b000000: cls_o = CLS_ALU;     // register form
            6'b001???: cls_o = CLS_ALU;     // immediate forms
            6'b000010: cls_o = CLS_JUMP;
            6'b00010?: cls_o = CLS_BRANCH;
            6'b100???: cls_o = CLS_MEM;     // loads
            6'b101???: cls_o = CLS_MEM;     // stores
            default:   cls_o = CLS_BAD;
         endcase
      end
   end

   if (IMM_W < 1) begin : g_bad_width
      $error("pi_word_classify: opcode field leaves no operand bits");
   end

endmodule

// File: rtl/pi_pair_check.sv
module pi_pair_check
   import pair_issue_pkg::*;
#(
   parameter int ALIGN_W = 3
) (
   input  logic [ALIGN_W-1:0] pc_low_i,
   input  ins_class_e         cls0_i,
   input  ins_class_e         cls1_i,
   output fault_e             fault_o,
   output logic               iss0_o,
   output logic               iss1_o
);

   logic misaligned;
   logic undefined;
   logic misplaced;

   assign misaligned = (pc_low_i != '0);
   assign undefined  = (cls0_i == CLS_BAD) || (cls1_i == CLS_BAD);
   assign misplaced  = !fits_slot0(cls0_i) || !fits_slot1(cls1_i);

   // Fixed priority: address, then opcode, then slot role
   always_comb begin
      if (misaligned)     fault_o = FLT_MISALIGN;
      else if (undefined) fault_o = FLT_UNKNOWN;
      else if (misplaced) fault_o = FLT_PAIRING;
      else                fault_o = FLT_NONE;
   end

   assign iss0_o = (fault_o == FLT_NONE) && (cls0_i != CLS_NOP);
   assign iss1_o = (fault_o == FLT_NONE) && (cls1_i != CLS_NOP);

endmodule

// File: rtl/pi_next_pc.sv
module pi_next_pc
   import pair_issue_pkg::*;
#(
   parameter int PC_W     = 32,
   parameter int IMM_W    = 26,
   parameter int ALIGN_W  = 3
) (
   input  logic [PC_W-1:0]  pc_i,
   input  logic [IMM_W-1:0] imm0_i,
   input  ins_class_e       cls0_i,
   input  fault_e           fault_i,
   output logic [PC_W-1:0]  npc_o
);

   localparam int KEEP_W = PC_W - IMM_W - 2;
   localparam int STEP   = 1 << ALIGN_W;

   logic [PC_W-1:0] seq_pc;
   logic [PC_W-1:0] jmp_pc;

   assign seq_pc = pc_i + PC_W'(STEP);

   always_comb begin
      jmp_pc = {pc_i[PC_W-1 -: KEEP_W], imm0_i, 2'b00};
      jmp_pc[ALIGN_W-1:0] = '0;
   end

   always_comb begin
      if (fault_i != FLT_NONE)     npc_o = pc_i;
      else if (cls0_i == CLS_JUMP) npc_o = jmp_pc;
      else                         npc_o = seq_pc;
   end

   if (KEEP_W < 1) begin : g_bad_pc
      $error("pi_next_pc: PC too narrow for the jump region");
   end

endmodule

// File: rtl/pair_issue_unit.sv
module pair_issue_unit
   import pair_issue_pkg::*;
#(
   parameter int              PC_W      = 32,
   parameter int              INS_W     = 32,
   parameter int              OPC_W     = 6,
   parameter logic [PC_W-1:0] RESET_PC  = '0,
   parameter bit              SLOT0_LOW = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               fetch_vld_i,
   input  logic [PC_W-1:0]    fetch_pc_i,
   input  logic [2*INS_W-1:0] fetch_bundle_i,
   output logic               alu_vld_o,
   output logic [INS_W-1:0]   alu_ins_o,
   output logic               mem_vld_o,
   output logic [INS_W-1:0]   mem_ins_o,
   output logic [1:0]         fault_o,
   output logic [PC_W-1:0]    next_pc_o
);

   localparam int BUNDLE_W = 2 * INS_W;
   localparam int ALIGN_W  = $clog2(BUNDLE_W / 8);
   localparam int IMM_W    = INS_W - OPC_W;

   if (OPC_W != 6) begin : g_chk_opc
      $error("pair_issue_unit: classifier is written for a 6-bit opcode");
   end
   if (INS_W % 8 != 0) begin : g_chk_ins
      $error("pair_issue_unit: instruction width must be whole bytes");
   end
   if (PC_W < IMM_W + 3) begin : g_chk_pc
      $error("pair_issue_unit: PC narrower than jump target");
   end

   logic [INS_W-1:0] w0, w1;
   ins_class_e       cls0, cls1;
   fault_e           flt;
   logic             iss0, iss1;
   logic [PC_W-1:0]  npc;

   // Word order within the bundle
   if (SLOT0_LOW) begin : g_low_first
      assign w0 = fetch_bundle_i[INS_W-1:0];
      assign w1 = fetch_bundle_i[BUNDLE_W-1:INS_W];
   end else begin : g_high_first
      assign w0 = fetch_bundle_i[BUNDLE_W-1:INS_W];
      assign w1 = fetch_bundle_i[INS_W-1:0];
   end

   pi_word_classify #(.INS_W(INS_W), .OPC_W(OPC_W)) u_cls0 (.word_i(w0), .cls_o(cls0));
   pi_word_classify #(.INS_W(INS_W), .OPC_W(OPC_W)) u_cls1 (.word_i(w1), .cls_o(cls1));

   pi_pair_check #(.ALIGN_W(ALIGN_W)) u_pair (
      .pc_low_i (fetch_pc_i[ALIGN_W-1:0]),
      .cls0_i   (cls0),
      .cls1_i   (cls1),
      .fault_o  (flt),
      .iss0_o   (iss0),
      .iss1_o   (iss1)
   );

   pi_next_pc #(.PC_W(PC_W), .IMM_W(IMM_W), .ALIGN_W(ALIGN_W)) u_npc (
      .pc_i    (fetch_pc_i),
      .imm0_i  (w0[IMM_W-1:0]),
      .cls0_i  (cls0),
      .fault_i (flt),
      .npc_o   (npc)
   );

   // Issue register
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         alu_vld_o <= 1'b0;
         alu_ins_o <= '0;
         mem_vld_o <= 1'b0;
         mem_ins_o <= '0;
         fault_o   <= FLT_NONE;
         next_pc_o <= RESET_PC;
      end else if (fetch_vld_i) begin
         alu_vld_o <= iss0;
         alu_ins_o <= iss0 ? w0 : '0;
         mem_vld_o <= iss1;
         mem_ins_o <= iss1 ? w1 : '0;
         fault_o   <= flt;
         next_pc_o <= npc;
      end else begin
         alu_vld_o <= 1'b0;
         alu_ins_o <= '0;
         mem_vld_o <= 1'b0;
         mem_ins_o <= '0;
         fault_o   <= FLT_NONE;
      end
   end

   // R6
   fault_quiets_slots_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fault_o != 2'd0) |-> (!alu_vld_o && !mem_vld_o));

   // R4
   mem_pipe_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_vld_o |-> (mem_ins_o[INS_W-1 -: 2] == 2'b10));

   // R4
   alu_pipe_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alu_vld_o |-> (alu_ins_o[INS_W-1 -: 2] == 2'b00));

   // R11
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fetch_vld_i |=> (!alu_vld_o && !mem_vld_o && fault_o == 2'd0 && $stable(next_pc_o)));

   // R10
   aligned_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fetch_vld_i && fetch_pc_i[ALIGN_W-1:0] == '0) |=> (next_pc_o[ALIGN_W-1:0] == '0));

   // R8
   misalign_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fetch_vld_i && fetch_pc_i[ALIGN_W-1:0] != '0) |=>
      (fault_o == 2'd1 && next_pc_o == $past(fetch_pc_i)));

endmodule

// File: tb/sim_pair_issue_unit.sv
`timescale 1ns/100ps
module sim_pair_issue_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vld = 1'b0;
   logic [31:0] pc = '0;
   logic [63:0] bund = '0;
   logic        alu_v, mem_v;
   logic [31:0] alu_i, mem_i, npc;
   logic [1:0]  flt;

   int n_chk = 0;
   int n_bad = 0;

   // expected state
   logic        e_alu_v, e_mem_v;
   logic [31:0] e_alu_i, e_mem_i, e_npc;
   logic [1:0]  e_flt;

   always #2.5 clk = ~clk;

   pair_issue_unit u0 (
      .clk_i(clk), .rst_ni(rst_n), .fetch_vld_i(vld), .fetch_pc_i(pc),
      .fetch_bundle_i(bund), .alu_vld_o(alu_v), .alu_ins_o(alu_i),
      .mem_vld_o(mem_v), .mem_ins_o(mem_i), .fault_o(flt), .next_pc_o(npc)
   );

   // 0 nop, 1 alu, 2 branch, 3 jump, 4 mem, 5 undefined
   function automatic int kind(input logic [31:0] w);
      int op;
      op = int'(w >> 26);
      if (w == 32'd0) return 0;
      if (op == 0 || (op >= 8 && op <= 15)) return 1;
      if (op == 4 || op == 5) return 2;
      if (op == 2) return 3;
      if (op >= 32 && op <= 47) return 4;
      return 5;
   endfunction

   task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      cmp(tag, "alu_vld", 32'(alu_v), 32'(e_alu_v));
      cmp(tag, "alu_ins", alu_i, e_alu_i);
      cmp(tag, "mem_vld", 32'(mem_v), 32'(e_mem_v));
      cmp(tag, "mem_ins", mem_i, e_mem_i);
      cmp(tag, "fault", 32'(flt), 32'(e_flt));
      cmp(tag, "next_pc", npc, e_npc);
   endtask

   // Drive one cycle at a falling edge, predict, check at the next falling edge
   task automatic step(input logic v, input logic [31:0] p, input logic [63:0] b, input string tag);
      logic [31:0] s0, s1;
      int k0, k1;
      vld = v; pc = p; bund = b;
      s0 = b[31:0]; s1 = b[63:32];
      k0 = kind(s0); k1 = kind(s1);
      e_alu_v = 1'b0; e_mem_v = 1'b0; e_alu_i = '0; e_mem_i = '0; e_flt = 2'd0;
      if (v) begin
         if ((p % 8) != 0)                             e_flt = 2'd1;
         else if (k0 == 5 || k1 == 5)                  e_flt = 2'd2;
         else if (k0 == 4 || (k1 != 0 && k1 != 4))     e_flt = 2'd3;
         if (e_flt != 2'd0) begin
            e_npc = p;
         end else begin
            e_alu_v = (k0 != 0); e_alu_i = e_alu_v ? s0 : '0;
            e_mem_v = (k1 != 0); e_mem_i = e_mem_v ? s1 : '0;
            if (k0 == 3) e_npc = ((p & 32'hF000_0000) | ((s0 & 32'h03FF_FFFF) << 2)) & ~32'd7;
            else         e_npc = p + 32'd8;
         end
      end
      @(negedge clk);
      check_all(tag);
   endtask

   function automatic logic [63:0] pair(input logic [31:0] hi, input logic [31:0] lo);
      return {hi, lo};
   endfunction

   localparam logic [31:0] ADD  = 32'h0022_1820; // r3 <- r1 + r2
   localparam logic [31:0] ADDI = 32'h2021_0004;
   localparam logic [31:0] BEQ  = 32'h1022_0003;
   localparam logic [31:0] LW3  = 32'h8C64_0000; // load using r3
   localparam logic [31:0] LW   = 32'h8C43_0000;
   localparam logic [31:0] SW   = 32'hAC43_0004;
   localparam logic [31:0] JMP  = 32'h080A_BCDF; // imm low bit set
   localparam logic [31:0] UND0 = 32'hFC00_0000;
   localparam logic [31:0] UND1 = 32'h4400_0001;

   initial begin : watchdog
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      e_alu_v = 0; e_mem_v = 0; e_alu_i = '0; e_mem_i = '0; e_flt = '0; e_npc = '0;
      repeat (3) @(negedge clk);
      check_all("R1");                 // in reset
      rst_n = 1'b1;
      step(1'b0, 32'h0, 64'h0, "R1");  // released, idle

      step(1'b1, 32'h0000_1000, pair(LW, ADD), "R2");
      step(1'b1, 32'h0000_1008, pair(SW, BEQ), "R4");
      step(1'b1, 32'h0000_1010, pair(LW, 32'h0), "R5");
      step(1'b1, 32'h0000_1018, pair(32'h0, ADDI), "R5");
      step(1'b1, 32'h0000_1020, 64'h0, "R5");
      step(1'b1, 32'h0000_1028, pair(LW, SW), "R6");   // mem in slot 0
      step(1'b1, 32'h0000_1030, pair(ADD, ADDI), "R6"); // alu in slot 1
      step(1'b1, 32'h0000_1038, pair(JMP, 32'h0), "R6");
      step(1'b1, 32'h0000_1040, pair(LW, UND0), "R7");
      step(1'b1, 32'h0000_1048, pair(UND1, LW), "R7");  // undefined beats misplaced
      step(1'b1, 32'h0000_1054, pair(LW, ADD), "R8");
      step(1'b1, 32'h0000_1061, pair(UND1, LW), "R8");  // misaligned beats both
      step(1'b1, 32'h0000_2000, pair(LW, BEQ), "R9");
      step(1'b1, 32'h3000_4000, pair(SW, JMP), "R10");
      step(1'b1, 32'h5000_0008, pair(32'h0, JMP), "R10");
      step(1'b0, 32'h0000_0003, pair(ADD, LW), "R11");
      step(1'b0, 32'h0000_0010, pair(UND0, UND1), "R11");
      step(1'b1, 32'h0000_3000, pair(LW3, ADD), "R12");

      for (int i = 0; i < 400; i++) begin : mix
         logic [31:0] pick [6];
         logic [31:0] a, b, p;
         pick[0] = 32'h0; pick[1] = ADD ^ (i & 32'hFF); pick[2] = BEQ;
         pick[3] = JMP ^ (32'(i) << 4); pick[4] = LW ^ 32'(i); pick[5] = $urandom;
         a = pick[$urandom % 6];
         b = pick[$urandom % 6];
         p = ($urandom % 8 == 0) ? $urandom : ($urandom & ~32'd7);
         step(($urandom % 5) != 0, p, pair(b, a), "R3");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

endmodule